// File: doc/BRIEF.md
# Two-Section Falling-Edge Ripple Counter

This block is a four-bit binary up-counter built from toggle flip-flops and split into two sections that run independently. The low section is a single divide-by-two stage with its own clock. The high section is a divide-by-eight chain with a second clock. Both sections act only on falling clock edges. Inside the high section each stage takes its clock from the output of the stage below it, so the bits settle one after another rather than at the same instant.

When the low output is wired back to the high-section clock, the two sections form one divide-by-sixteen counter. In that setup `{q_hi, q_lo}` steps through 0 to 15 and then starts again at 0. When the high-section clock is driven from somewhere else, the sections serve as two separate dividers. The block has two active-high reset inputs that are ANDed together. Their combination clears every stage at once, without waiting for any clock, and holds the stages clear while it lasts.

Top module: `ripple_div_counter`

## Requirements
- R1: While both `rst_a` and `rst_b` are high, `q_lo` is 0 and every bit of `q_hi` is 0.
- R2: When reset is inactive, `q_lo` inverts on every falling edge of `clk_lo`.
- R3: Rising edges of `clk_lo` and `clk_hi` leave `q_lo` and `q_hi` unchanged.
- R4: When reset is inactive, each falling edge of `clk_hi` adds one to `q_hi` modulo 8. `q_hi[0]` is the least significant bit, so the value after 7 is 0.
- R5: Inside the high section, `q_hi[0]` toggles on falling edges of `clk_hi`. Each higher bit `q_hi[i]` toggles on a falling edge of `q_hi[i-1]`.
- R6: When only one of `rst_a` or `rst_b` is high, the counter keeps counting as if neither were high.
- R7: The reset acts asynchronously. When both inputs go high, the outputs become 0 with no clock edge. They stay at 0 through clock edges for as long as both inputs remain high.
- R8: With `q_lo` wired to `clk_hi`, the value `{q_hi, q_lo}` rises by one after each falling edge of `clk_lo`.
- R9: With `q_lo` wired to `clk_hi`, the value after 15 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_lo | input | 1 | Clock of the divide-by-two section, falling-edge active |
| clk_hi | input | 1 | Clock of the divide-by-eight section, falling-edge active |
| rst_a | input | 1 | First reset input, active high, ANDed with `rst_b` |
| rst_b | input | 1 | Second reset input, active high, ANDed with `rst_a` |
| q_lo | output | 1 | Divide-by-two output, count bit 0 |
| q_hi | output | HI_STAGES | Divide-by-eight outputs, count bits 1 and up |

## Verification
The assertions assume two things. First, a change on either reset input never falls on a clock edge. Second, once reset is released, every stage clock comes only from the bench's clock source or from another stage output. The bench keeps resets and the manual `clk_hi` pulses a few nanoseconds away from any `clk_lo` edge. It switches the source of `clk_hi` only while reset is held, so that the switch cannot create a false falling edge. Outputs are sampled one nanosecond after a rising edge of `clk_lo`, which is where the ripple from the previous falling edge has settled.

// File: rtl/ripple_pkg.sv
package ripple_pkg;
  // Default depth of the upper divide chain (divide-by-8).
  localparam int unsigned HI_STAGES_DEF = 3;
endpackage

// File: rtl/tff_stage.sv
module tff_stage (
  input  logic clk_n,
  input  logic rst,
  output logic q
);
  always_ff @(negedge clk_n or posedge rst) begin
    if (rst) q <= 1'b0;
    else     q <= ~q;
  end

  // Checker-side flag: an edge has already occurred since the last reset.
  logic seen_edge;
  always_ff @(negedge clk_n or posedge rst) begin
    if (rst) seen_edge <= 1'b0;
    else     seen_edge <= 1'b1;
  end

  // R2 (also R5 for chain stages): output flips between consecutive falling edges
  assert_stage_toggles_R2: assert property (@(negedge clk_n) disable iff (rst)
    seen_edge |-> (q != $past(q)));
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk_n,
  input  logic              rst,
  output logic [STAGES-1:0] q
);
  logic [STAGES-1:0] stage_clk;

  assign stage_clk[0] = clk_n;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i > 0) begin : g_link
      // R5: each stage is clocked by the falling edge of the one below
      assign stage_clk[i] = q[i-1];
    end
    tff_stage u_stage (
      .clk_n (stage_clk[i]),
      .rst   (rst),
      .q     (q[i])
    );
  end

  logic seen_edge;
  always_ff @(negedge clk_n or posedge rst) begin
    if (rst) seen_edge <= 1'b0;
    else     seen_edge <= 1'b1;
  end

  // R4: settled value advances by one per falling input edge
  assert_chain_counts_R4: assert property (@(negedge clk_n) disable iff (rst)
    seen_edge |-> (q == STAGES'($past(q) + 1'b1)));

  // R4: all-ones rolls over to zero
  assert_upper_wrap_R4: assert property (@(negedge clk_n) disable iff (rst)
    (seen_edge && ($past(q) == {STAGES{1'b1}})) |-> (q == '0));
endmodule

// File: rtl/ripple_div_counter.sv
module ripple_div_counter
  import ripple_pkg::*;
#(
  parameter int unsigned HI_STAGES = HI_STAGES_DEF
) (
  input  logic                 clk_lo,
  input  logic                 clk_hi,
  input  logic                 rst_a,
  input  logic                 rst_b,
  output logic                 q_lo,
  output logic [HI_STAGES-1:0] q_hi
);
  // R6: reset only when both inputs are high
  logic rst_both;
  assign rst_both = rst_a & rst_b;

  tff_stage u_lo (
    .clk_n (clk_lo),
    .rst   (rst_both),
    .q     (q_lo)
  );

  ripple_chain #(.STAGES(HI_STAGES)) u_hi (
    .clk_n (clk_hi),
    .rst   (rst_both),
    .q     (q_hi)
  );

  // R1/R7: with both resets high, every stage reads zero at clock activity
  assert_reset_clears_R7: assert property (@(posedge clk_lo)
    (rst_a && rst_b) |-> (!q_lo && (q_hi == '0)));
endmodule

// File: tb/sim_ripple_div_counter.sv
module sim_ripple_div_counter;
  logic       clk_lo = 1'b0;
  logic       clk_hi_drv = 1'b0;
  logic       cascade = 1'b1;
  logic       rst_a = 1'b1;
  logic       rst_b = 1'b1;
  logic       q_lo;
  logic [2:0] q_hi;
  logic       clk_hi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int exp_cnt = 0;

  always #10 clk_lo = ~clk_lo;  // 50 MHz

  assign clk_hi = cascade ? q_lo : clk_hi_drv;

  ripple_div_counter #(.HI_STAGES(3)) u0 (
    .clk_lo (clk_lo),
    .clk_hi (clk_hi),
    .rst_a  (rst_a),
    .rst_b  (rst_b),
    .q_lo   (q_lo),
    .q_hi   (q_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int full_count();
    return int'({q_hi, q_lo});
  endfunction

  // Requirement tag for a cascaded count step.
  function automatic string step_req(input int v);
    if (v == 0) return "R9";
    if (v[1:0] == 2'b00) return "R5";
    return "R8";
  endfunction

  task automatic t_reset_state();
    #15;
    chk("R1", full_count(), 0);
    @(posedge clk_lo); #1;
    chk("R1", full_count(), 0);
  endtask

  task automatic t_cascade_count();
    @(posedge clk_lo); #1;
    rst_a = 1'b0; rst_b = 1'b0;
    exp_cnt = 0;
    chk("R3", full_count(), 0);
    for (int i = 0; i < 34; i++) begin
      @(posedge clk_lo); #1;
      exp_cnt = (exp_cnt + 1) % 16;
      chk(step_req(exp_cnt), full_count(), exp_cnt);
    end
  endtask

  task automatic t_single_reset();
    @(posedge clk_lo); #1;
    rst_a = 1'b1;
    exp_cnt = (exp_cnt + 1) % 16;
    chk("R6", full_count(), exp_cnt);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk_lo); #1;
      exp_cnt = (exp_cnt + 1) % 16;
      chk("R6", full_count(), exp_cnt);
    end
    rst_a = 1'b0; rst_b = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk_lo); #1;
      exp_cnt = (exp_cnt + 1) % 16;
      chk("R6", full_count(), exp_cnt);
    end
    rst_b = 1'b0;
  endtask

  task automatic t_async_reset();
    @(posedge clk_lo); #1;
    exp_cnt = (exp_cnt + 1) % 16;
    chk("R8", full_count(), exp_cnt);
    @(negedge clk_lo); #3;
    rst_a = 1'b1; rst_b = 1'b1;
    #2;
    chk("R7", full_count(), 0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_lo); #1;
      chk("R7", full_count(), 0);
    end
    rst_a = 1'b0; rst_b = 1'b0;
    exp_cnt = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_lo); #1;
      exp_cnt = (exp_cnt + 1) % 16;
      chk("R8", full_count(), exp_cnt);
    end
  endtask

  task automatic t_split_sections();
    int exp_hi;
    bit exp_lo;
    @(posedge clk_lo); #1;
    rst_a = 1'b1; rst_b = 1'b1;
    #1;
    clk_hi_drv = 1'b0;
    cascade = 1'b0;
    #1;
    chk("R1", full_count(), 0);
    @(posedge clk_lo); #1;
    rst_a = 1'b0; rst_b = 1'b0;
    exp_hi = 0;
    exp_lo = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk_lo); #1;
      exp_lo = ~exp_lo;
      chk("R2", int'(q_lo), int'(exp_lo));
      #2 clk_hi_drv = 1'b1;
      #2 chk("R3", int'(q_hi), exp_hi);
      #2 clk_hi_drv = 1'b0;
      #1;
      exp_hi = (exp_hi + 1) % 8;
      chk("R4", int'(q_hi), exp_hi);
      chk("R2", int'(q_lo), int'(exp_lo));
    end
  endtask

  initial begin
    t_reset_state();
    t_cascade_count();
    t_single_reset();
    t_async_reset();
    t_split_sections();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #4000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule